// File: doc/BRIEF.md
# Frame Pointer Controller with Deferred Swap

This block is the register front end of a video frame reader. It keeps two frame-buffer base addresses. The front one is the image being scanned out. The back one is the image software is drawing into. Software asks for the two to be exchanged, and the exchange is held back until the next vertical sync pulse, so a frame is never torn mid-scan. A status flag stays high from the request until the exchange has happened.

The block also produces the fetch address for each displayed pixel of a 320x240 image with 2-byte pixels. The display timing advances it one screen pixel or one screen line at a time. Every stored pixel covers a 2x2 patch of the 640x480 screen, so the image column and row each move once per two screen steps. Two address forms can be selected: a row/column form, where the row sits at bit 10 and the column at bit 1, and a packed form made of consecutive pixel indices.

The register bus is word addressed by byte offset, and bits 1:0 of the offset are ignored. Read data is registered.

Top module: `frame_ptr_ctrl`

## Requirements
- R1: After reset, both base addresses are 0x08000000, the swap flag is 0, the address form is row/column, fetch enable is 1, `pix_addr` is 0x08000000 and `bus_rdata` is 0.
- R2: Offset 0x4 holds the back base, which reads back what was written. Offset 0x0 reads the front base. A write to 0x0 with any value other than 1 changes nothing.
- R3: A write of exactly 1 to offset 0x0 sets the swap flag (bit 0 of offset 0xC) on the next cycle and leaves both bases unchanged.
- R4: A `vsync` pulse while the flag is set exchanges front and back and clears the flag on the same edge. A `vsync` pulse with no flag set changes nothing.
- R5: Several requests made before one `vsync` produce one exchange. A second `vsync` does not exchange again.
- R6: A request made in the same cycle as `vsync` stays pending until the next `vsync`. A write to 0x4 in the same cycle as an exchange puts the written value in the back base, while the front base takes the old back value.
- R7: Offset 0x8 reads 320 in bits 15:0 and 240 in bits 31:16. Offset 0xC reads 9 (column address width) in bits 23:16 and 8 (row address width) in bits 31:24.
- R8: A write to 0xC loads bit 1 (address form: 0 row/column, 1 packed) and bit 2 (`fetch_en`). Bit 0 of the written value is ignored.
- R9: In row/column form, `pix_addr` = front + (y<<10) + (x<<1). Pixel (319,239) gives front + 0x3BE7E.
- R10: In packed form, `pix_addr` = front + 2*(y*320 + x). Pixel (319,239) gives front + 0x257FE.
- R11: Two `pix_adv` pulses move x by one and two `line_adv` pulses move y by one. `line_adv` returns to column 0. Screen column 640 wraps to column 0.
- R12: `vsync` restarts at pixel (0,0) and addresses from the front base as updated on that same edge. Priority is `vsync`, then `line_adv`, then `pix_adv`.
- R13: `bus_rdata` shows the register selected by `bus_addr` one cycle after the address is presented. `pix_addr` shows the scan position one cycle after that position is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| vsync | input | 1 | One-cycle vertical sync pulse |
| pix_adv | input | 1 | Advance one screen pixel |
| line_adv | input | 1 | Advance one screen line |
| pix_addr | output | 32 | Registered pixel fetch address |
| fetch_en | output | 1 | Fetch enable bit from control |

## Verification
Swap requests are tried in four patterns: a single request, repeated requests before one sync, a request landing on the sync cycle itself, and a back-base write landing on the swap cycle. These separate a deferred exchange from an immediate one, a counting request from a merged one, and the two possible priority orders. The scan is walked to the last image pixel, and the same point is then reached in the packed form. This separates the two address formulas, exposes a missing replication step or a wrong row stride, and a further step checks the wrap at the line end. A sync after a pending swap shows whether the restarted scan picks up the new front base.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    RG_FRONT = 2'd0,
    RG_BACK  = 2'd1,
    RG_RES   = 2'd2,
    RG_STAT  = 2'd3
  } reg_sel_e;

  localparam int STAT_PEND = 0;
  localparam int STAT_LIN  = 1;
  localparam int STAT_EN   = 2;
  localparam int STAT_XW_LO = 16;
  localparam int STAT_YW_LO = 24;
endpackage

// File: rtl/fpc_regfile.sv
module fpc_regfile
  import fpc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] DEF_BASE = 32'h0800_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  reg_sel_e          sel,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              vsync,
  output logic [AW-1:0]     front_base,
  output logic [AW-1:0]     back_base,
  output logic              swap_pend,
  output logic              mode_lin,
  output logic              fetch_en,
  output logic              swap_req,
  output logic              back_wr
);
  logic do_swap;

  assign swap_req = wen && (sel == RG_FRONT) && (wdata == BUS_W'(1));
  assign back_wr  = wen && (sel == RG_BACK);
  assign do_swap  = vsync && swap_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      front_base <= AW'(DEF_BASE);
      back_base  <= AW'(DEF_BASE);
      swap_pend  <= 1'b0;
      mode_lin   <= 1'b0;
      fetch_en   <= 1'b1;
    end else begin
      if (do_swap) front_base <= back_base;
      if (back_wr)      back_base <= wdata[AW-1:0];
      else if (do_swap) back_base <= front_base;
      swap_pend <= (swap_pend && !vsync) || swap_req;
      if (wen && (sel == RG_STAT)) begin
        mode_lin <= wdata[STAT_LIN];
        fetch_en <= wdata[STAT_EN];
      end
    end
  end
endmodule

// File: rtl/fpc_scan.sv
module fpc_scan #(
  parameter int IMG_W  = 320,
  parameter int IMG_H  = 240,
  parameter int X_BITS = 9,
  parameter int Y_BITS = 8,
  parameter int REP    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync,
  input  logic              pix_adv,
  input  logic              line_adv,
  output logic [X_BITS-1:0] scan_x,
  output logic [Y_BITS-1:0] scan_y
);
  localparam int PH_W = (REP > 1) ? $clog2(REP) : 1;
  localparam logic [X_BITS-1:0] X_LAST = X_BITS'(IMG_W - 1);
  localparam logic [Y_BITS-1:0] Y_LAST = Y_BITS'(IMG_H - 1);

  logic x_step;
  logic y_step;

  generate
    if (REP > 1) begin : g_rep
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(REP - 1);
      logic [PH_W-1:0] xph;
      logic [PH_W-1:0] yph;
      always_ff @(posedge clk) begin
        if (rst || vsync) begin
          xph <= '0;
          yph <= '0;
        end else if (line_adv) begin
          xph <= '0;
          yph <= (yph == PH_LAST) ? '0 : yph + 1'b1;
        end else if (pix_adv) begin
          xph <= (xph == PH_LAST) ? '0 : xph + 1'b1;
        end
      end
      assign x_step = pix_adv && (xph == PH_LAST);
      assign y_step = (yph == PH_LAST);
    end else begin : g_norep
      assign x_step = pix_adv;
      assign y_step = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || vsync) begin
      scan_x <= '0;
      scan_y <= '0;
    end else if (line_adv) begin
      scan_x <= '0;
      if (y_step) scan_y <= (scan_y == Y_LAST) ? '0 : scan_y + 1'b1;
    end else if (x_step) begin
      scan_x <= (scan_x == X_LAST) ? '0 : scan_x + 1'b1;
    end
  end
endmodule

// File: rtl/fpc_addr.sv
module fpc_addr #(
  parameter int          AW       = 32,
  parameter int          IMG_W    = 320,
  parameter int          X_BITS   = 9,
  parameter int          Y_BITS   = 8,
  parameter int          BYTE_SH  = 1,
  parameter logic [31:0] DEF_BASE = 32'h0800_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     base,
  input  logic              mode_lin,
  input  logic [X_BITS-1:0] x,
  input  logic [Y_BITS-1:0] y,
  output logic [AW-1:0]     pix_addr
);
  localparam int ROW_SH = X_BITS + BYTE_SH;

  logic [AW-1:0] xy_off;
  logic [AW-1:0] lin_idx;
  logic [AW-1:0] lin_off;

  always_comb begin
    xy_off  = (AW'(y) << ROW_SH) | (AW'(x) << BYTE_SH);
    lin_idx = AW'(y) * AW'(IMG_W) + AW'(x);
    lin_off = lin_idx << BYTE_SH;
  end

  always_ff @(posedge clk) begin
    if (rst) pix_addr <= AW'(DEF_BASE);
    else     pix_addr <= base + (mode_lin ? lin_off : xy_off);
  end
endmodule

// File: rtl/frame_ptr_ctrl.sv
module frame_ptr_ctrl
  import fpc_pkg::*;
#(
  parameter int          IMG_W    = 320,
  parameter int          IMG_H    = 240,
  parameter int          X_BITS   = 9,
  parameter int          Y_BITS   = 8,
  parameter int          REP      = 2,
  parameter int          BYTE_SH  = 1,
  parameter logic [31:0] DEF_BASE = 32'h0800_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wen,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        vsync,
  input  logic        pix_adv,
  input  logic        line_adv,
  output logic [31:0] pix_addr,
  output logic        fetch_en
);
  localparam int AW = BUS_W;

  reg_sel_e          sel;
  logic [AW-1:0]     front_base;
  logic [AW-1:0]     back_base;
  logic              swap_pend;
  logic              mode_lin;
  logic              swap_req;
  logic              back_wr;
  logic [X_BITS-1:0] scan_x;
  logic [Y_BITS-1:0] scan_y;
  logic [BUS_W-1:0]  stat_word;
  logic [BUS_W-1:0]  res_word;
  logic [BUS_W-1:0]  rd_mux;

  assign sel = reg_sel_e'(bus_addr[3:2]);

  fpc_regfile #(.AW(AW), .DEF_BASE(DEF_BASE)) u_regs (
    .clk(clk), .rst(rst), .wen(bus_wen), .sel(sel), .wdata(bus_wdata),
    .vsync(vsync), .front_base(front_base), .back_base(back_base),
    .swap_pend(swap_pend), .mode_lin(mode_lin), .fetch_en(fetch_en),
    .swap_req(swap_req), .back_wr(back_wr)
  );

  fpc_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H), .X_BITS(X_BITS), .Y_BITS(Y_BITS),
             .REP(REP)) u_scan (
    .clk(clk), .rst(rst), .vsync(vsync), .pix_adv(pix_adv),
    .line_adv(line_adv), .scan_x(scan_x), .scan_y(scan_y)
  );

  fpc_addr #(.AW(AW), .IMG_W(IMG_W), .X_BITS(X_BITS), .Y_BITS(Y_BITS),
             .BYTE_SH(BYTE_SH), .DEF_BASE(DEF_BASE)) u_addr (
    .clk(clk), .rst(rst), .base(front_base), .mode_lin(mode_lin),
    .x(scan_x), .y(scan_y), .pix_addr(pix_addr)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STAT_YW_LO +: 8] = 8'(Y_BITS);
    stat_word[STAT_XW_LO +: 8] = 8'(X_BITS);
    stat_word[STAT_EN]         = fetch_en;
    stat_word[STAT_LIN]        = mode_lin;
    stat_word[STAT_PEND]       = swap_pend;
    res_word = {16'(IMG_H), 16'(IMG_W)};
    case (sel)
      RG_FRONT: rd_mux = front_base;
      RG_BACK:  rd_mux = back_base;
      RG_RES:   rd_mux = res_word;
      default:  rd_mux = stat_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/frame_ptr_ctrl_chk.sv
module frame_ptr_ctrl_chk #(
  parameter int AW     = 32,
  parameter int IMG_W  = 320,
  parameter int IMG_H  = 240,
  parameter int X_BITS = 9,
  parameter int Y_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              vsync,
  input logic              swap_req,
  input logic              swap_pend,
  input logic              back_wr,
  input logic [AW-1:0]     front_base,
  input logic [AW-1:0]     back_base,
  input logic [X_BITS-1:0] scan_x,
  input logic [Y_BITS-1:0] scan_y
);
  p_req_sets_r3: assert property (@(posedge clk) disable iff (rst)
    swap_req |=> swap_pend);

  p_swap_exchange_r4: assert property (@(posedge clk) disable iff (rst)
    (vsync && swap_pend && !back_wr) |=>
      (front_base == $past(back_base) && back_base == $past(front_base)));

  p_pend_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (vsync && swap_pend && !swap_req) |=> !swap_pend);

  p_front_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(vsync && swap_pend) |=> $stable(front_base));

  p_scan_x_range_r11: assert property (@(posedge clk) disable iff (rst)
    scan_x < X_BITS'(IMG_W));

  p_scan_y_range_r11: assert property (@(posedge clk) disable iff (rst)
    scan_y < Y_BITS'(IMG_H));

  p_restart_r12: assert property (@(posedge clk) disable iff (rst)
    vsync |=> (scan_x == '0 && scan_y == '0));
endmodule

bind frame_ptr_ctrl frame_ptr_ctrl_chk #(
  .AW(32), .IMG_W(IMG_W), .IMG_H(IMG_H), .X_BITS(X_BITS), .Y_BITS(Y_BITS)
) u_chk (
  .clk(clk), .rst(rst), .vsync(vsync), .swap_req(swap_req),
  .swap_pend(swap_pend), .back_wr(back_wr), .front_base(front_base),
  .back_base(back_base), .scan_x(scan_x), .scan_y(scan_y)
);

// File: tb/sim_frame_ptr_ctrl.sv
module sim_frame_ptr_ctrl;
  localparam logic [31:0] DEF = 32'h0800_0000;
  localparam logic [31:0] B1  = 32'h0010_0000;
  localparam logic [31:0] B2  = 32'h0020_0000;
  localparam int SCR_W = 640;
  localparam int SCR_H = 480;
  localparam int IW    = 320;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        vsync = 1'b0;
  logic        pix_adv = 1'b0;
  logic        line_adv = 1'b0;
  logic [31:0] pix_addr;
  logic        fetch_en;

  frame_ptr_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vsync(vsync),
    .pix_adv(pix_adv), .line_adv(line_adv), .pix_addr(pix_addr),
    .fetch_en(fetch_en)
  );

  always #5 clk = ~clk;

  int    errs = 0;
  int    checks = 0;
  string phase = "R1";

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: screen coordinates, base pair, flags
  logic [31:0] m_front, m_back, exp_addr, exp_rd;
  bit          m_pend, m_lin, m_en;
  int          m_sx, m_sy;

  function automatic logic [31:0] model_addr();
    int px, py;
    px = m_sx / 2;
    py = m_sy / 2;
    if (m_lin) return m_front + 32'((py * IW + px) * 2);
    return m_front + 32'(py * 1024 + px * 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_front = DEF; m_back = DEF; m_pend = 0; m_lin = 0; m_en = 1;
      m_sx = 0; m_sy = 0; exp_addr = DEF; exp_rd = 0;
    end else begin
      logic [31:0] nf, nb;
      bit swap, req;
      case (bus_addr[3:2])
        2'd0: exp_rd = m_front;
        2'd1: exp_rd = m_back;
        2'd2: exp_rd = {16'd240, 16'd320};
        default: exp_rd = {8'd8, 8'd9, 13'd0, m_en, m_lin, m_pend};
      endcase
      exp_addr = model_addr();
      swap = vsync && m_pend;
      req  = bus_wen && bus_addr[3:2] == 2'd0 && bus_wdata == 32'd1;
      nf = swap ? m_back : m_front;
      nb = swap ? m_front : m_back;
      if (bus_wen && bus_addr[3:2] == 2'd1) nb = bus_wdata;
      m_front = nf; m_back = nb;
      m_pend = (m_pend && !vsync) || req;
      if (bus_wen && bus_addr[3:2] == 2'd3) begin
        m_lin = bus_wdata[1]; m_en = bus_wdata[2];
      end
      if (vsync) begin m_sx = 0; m_sy = 0; end
      else if (line_adv) begin m_sx = 0; m_sy = (m_sy + 1) % SCR_H; end
      else if (pix_adv) m_sx = (m_sx + 1) % SCR_W;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk({phase, " pix_addr"}, pix_addr, exp_addr);
      chk({phase, " rdata"}, bus_rdata, exp_rd);
      chk({phase, " fetch_en"}, {31'd0, fetch_en}, {31'd0, m_en});
    end
  end

  task automatic step(bit w, logic [3:0] a, logic [31:0] d, bit vs, bit pa, bit la);
    bus_wen = w; bus_addr = a; bus_wdata = d; vsync = vs; pix_adv = pa; line_adv = la;
    @(negedge clk);
    bus_wen = 0; bus_wdata = '0; vsync = 0; pix_adv = 0; line_adv = 0;
  endtask

  task automatic idle(); step(0, 4'h0, 0, 0, 0, 0); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d); step(1, a, d, 0, 0, 0); endtask
  task automatic sync(); step(0, 4'h0, 0, 1, 0, 0); endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, exp);
  endtask

  localparam logic [31:0] ST0 = 32'h0809_0004;

  task automatic walk_to_last();
    sync();
    for (int i = 0; i < SCR_H - 2; i++) step(0, 4'h0, 0, 0, 0, 1);
    for (int i = 0; i < SCR_W - 2; i++) step(0, 4'h0, 0, 0, 1, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    phase = "R1";
    chk("R1 pix_addr", pix_addr, DEF);
    chk("R1 fetch_en", {31'd0, fetch_en}, 32'd1);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(4'h0, DEF, "R1 front");
    rd(4'h4, DEF, "R1 back");
    rd(4'hC, ST0, "R1 status");
    // R7 / R13 read-only geometry words, one-cycle read latency
    phase = "R7";
    rd(4'h8, {16'd240, 16'd320}, "R7 R13 resolution");
    // R2 back writable, front ignores non-1 writes
    phase = "R2";
    wr(4'h4, B1);
    rd(4'h4, B1, "R2 back readback");
    wr(4'h0, 32'h0000_1234);
    rd(4'h0, DEF, "R2 front unchanged");
    rd(4'hC, ST0, "R2 no request");
    // R3 request
    phase = "R3";
    wr(4'h0, 32'd1);
    rd(4'hC, ST0 | 32'd1, "R3 flag set");
    rd(4'h0, DEF, "R3 front held");
    // R4 swap at sync, idle sync does nothing
    phase = "R4";
    sync();
    rd(4'h0, B1, "R4 front after swap");
    rd(4'h4, DEF, "R4 back after swap");
    rd(4'hC, ST0, "R4 flag cleared");
    sync();
    rd(4'h0, B1, "R4 no second swap");
    // R5 merged requests
    phase = "R5";
    wr(4'h0, 32'd1);
    wr(4'h0, 32'd1);
    sync();
    rd(4'h0, DEF, "R5 one swap");
    sync();
    rd(4'h0, DEF, "R5 merged");
    rd(4'h4, B1, "R5 back");
    // R6 request on sync cycle, back write on swap cycle
    phase = "R6";
    step(1, 4'h0, 32'd1, 1, 0, 0);
    rd(4'hC, ST0 | 32'd1, "R6 still pending");
    rd(4'h0, DEF, "R6 not swapped yet");
    sync();
    rd(4'h0, B1, "R6 deferred swap");
    wr(4'h0, 32'd1);
    step(1, 4'h4, B2, 1, 0, 0);
    rd(4'h0, DEF, "R6 front took old back");
    rd(4'h4, B2, "R6 write wins back");
    // R8 control write
    phase = "R8";
    wr(4'hC, 32'h0000_0003);
    rd(4'hC, 32'h0809_0002, "R8 form set, flag bit ignored");
    chk("R8 fetch_en low", {31'd0, fetch_en}, 32'd0);
    wr(4'hC, 32'h0000_0004);
    rd(4'hC, ST0, "R8 restored");
    // R11 replication
    phase = "R11";
    sync();
    step(0, 4'h0, 0, 0, 1, 0);
    idle();
    chk("R11 first screen pixel same", pix_addr, DEF);
    step(0, 4'h0, 0, 0, 1, 0);
    step(0, 4'h0, 0, 0, 1, 0);
    idle();
    chk("R11 x=1", pix_addr, DEF + 32'd2);
    step(0, 4'h0, 0, 0, 0, 1);
    idle();
    chk("R11 line start same row", pix_addr, DEF);
    step(0, 4'h0, 0, 0, 0, 1);
    idle();
    chk("R11 row 1", pix_addr, DEF + 32'h400);
    // R9 last pixel, row/column form
    phase = "R9";
    walk_to_last();
    chk("R9 last pixel", pix_addr, 32'h0803_BE7E);
    phase = "R11";
    step(0, 4'h0, 0, 0, 1, 0);
    step(0, 4'h0, 0, 0, 1, 0);
    idle();
    chk("R11 column wrap", pix_addr, 32'h0803_BC00);
    // R10 packed form
    phase = "R10";
    wr(4'hC, 32'h0000_0006);
    walk_to_last();
    chk("R10 last pixel", pix_addr, 32'h0802_57FE);
    wr(4'hC, 32'h0000_0004);
    // R12 sync restart with new front
    phase = "R12";
    step(0, 4'h0, 0, 0, 1, 0);
    step(0, 4'h0, 0, 0, 1, 0);
    wr(4'h0, 32'd1);
    step(0, 4'h0, 0, 1, 1, 1);
    idle();
    chk("R12 restart on new front", pix_addr, B2);
    repeat (4) idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule